// File: doc/BRIEF.md
# Timer Channel Control and Interrupt Register Bank

This block is the shared register window for a group of up to sixteen timer channels, eight by default. It stores four per-channel bit vectors: a run-enable vector, a halt vector, an interrupt pending vector and an interrupt mask vector. Software changes them only through paired write-one-to-set and write-one-to-clear addresses, so one bit can be changed without a read-modify-write. Each vector also has its own read-only address.

The pending and mask words are 32 bits wide. Channel n's full-match bit sits at position n, and its half-match bit sits sixteen positions higher. The channels send single-cycle full-match and half-match event pulses, and each pulse sets the matching pending bit. The block drives the enable and halt lines to the channels and one interrupt line. That line is high while any pending bit has a clear mask bit.

Top module: `tmr_ctl_bank`

## Requirements
- R1: After reset the enable vector is 0, every halt bit is 1, the pending word is 0, every implemented mask bit (positions 0..NUM_CH-1 and 16..16+NUM_CH-1) is 1, and irq is 0.
- R2: A write to offset 0x04 sets each enable bit written as 1, and a write to 0x08 clears each enable bit written as 1. Bits written as 0 keep their value. chanEnable shows the enable vector from the clock edge that takes the write.
- R3: A write to 0x1C sets halt bits and a write to 0x2C clears them, with 0-bits keeping their value. chanStop shows the halt vector from the clock edge that takes the write.
- R4: A write to 0x14 sets pending bits and a write to 0x18 clears them, with 0-bits keeping their value.
- R5: A write to 0x24 sets mask bits and a write to 0x28 clears them, with 0-bits keeping their value.
- R6: A one-cycle pulse on fullEvt[n] sets pending bit n, and a pulse on halfEvt[n] sets pending bit n+16. Either bit reads as 1 from the clock edge that samples the pulse.
- R7: When an event and a software clear of the same pending bit arrive in one cycle, the bit ends up set. Other bits named in that clear are cleared.
- R8: irq is 1 exactly when some pending bit is 1 and its mask bit is 0. Clearing a pending bit and then unmasking it leaves irq at 0 until a new event arrives.
- R9: Writes to the read offsets 0x00 (enable), 0x0C (halt), 0x10 (pending) and 0x20 (mask) change no stored bit. Pending and mask bits above the implemented channels can never be set and always read 0.
- R10: With no write in progress, rdData returns the addressed vector in the same cycle, zero-extended, at offsets 0x00, 0x0C, 0x10 and 0x20. Every other offset, including offsets that are not word aligned, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte offset inside the register window |
| wrData | input | 32 | Write data; each 1-bit selects a bit to set or clear |
| rdData | output | 32 | Read data for addr, combinational |
| fullEvt | input | NUM_CH | Full-match event pulses, one per channel |
| halfEvt | input | NUM_CH | Half-match event pulses, one per channel |
| chanEnable | output | NUM_CH | Run enable to each channel |
| chanStop | output | NUM_CH | Halt request to each channel |
| irq | output | 1 | Combined interrupt: any unmasked pending bit |

## Verification
The bench aims at the cycle in which a channel event and a software clear hit the same pending bit. A design that lets the clear win loses that event for good, and the pending word then reads the bit as 0. It also checks that 0-bits in set and clear writes leave their neighbours alone; a design that stores the written word outright shows wrong enable or halt lines. Writes to the four read offsets and all-ones writes to the pending and mask words are also checked: decoding that is too loose would change a vector, and missing masking would report bits above the implemented channels. The clear-then-unmask sequence is run to show that irq stays low, since a design that latches events in a separate path would raise it.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;

  localparam int WORD_W    = 32;
  localparam int HALF_BASE = 16;

  // Byte offsets of the register window
  localparam int OFS_EN_RD   = 'h00;
  localparam int OFS_EN_SET  = 'h04;
  localparam int OFS_EN_CLR  = 'h08;
  localparam int OFS_ST_RD   = 'h0C;
  localparam int OFS_FL_RD   = 'h10;
  localparam int OFS_FL_SET  = 'h14;
  localparam int OFS_FL_CLR  = 'h18;
  localparam int OFS_ST_SET  = 'h1C;
  localparam int OFS_MK_RD   = 'h20;
  localparam int OFS_MK_SET  = 'h24;
  localparam int OFS_MK_CLR  = 'h28;
  localparam int OFS_ST_CLR  = 'h2C;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic stopSet;
    logic stopClr;
    logic flagSet;
    logic flagClr;
    logic maskSet;
    logic maskClr;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_EN   = 3'd1,
    SEL_STOP = 3'd2,
    SEL_FLAG = 3'd3,
    SEL_MASK = 3'd4
  } rdSel_e;

  // Implemented positions of the pending and mask words
  function automatic logic [WORD_W-1:0] irqBits(input int numCh);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int i = 0; i < numCh; i++) begin
      v[i]             = 1'b1;
      v[i + HALF_BASE] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_ctl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output wrStrobe_t         strb,
  output rdSel_e            rdSel
);

  localparam logic [ADDR_W-1:0] A_EN_RD  = ADDR_W'(OFS_EN_RD);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFS_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFS_EN_CLR);
  localparam logic [ADDR_W-1:0] A_ST_RD  = ADDR_W'(OFS_ST_RD);
  localparam logic [ADDR_W-1:0] A_ST_SET = ADDR_W'(OFS_ST_SET);
  localparam logic [ADDR_W-1:0] A_ST_CLR = ADDR_W'(OFS_ST_CLR);
  localparam logic [ADDR_W-1:0] A_FL_RD  = ADDR_W'(OFS_FL_RD);
  localparam logic [ADDR_W-1:0] A_FL_SET = ADDR_W'(OFS_FL_SET);
  localparam logic [ADDR_W-1:0] A_FL_CLR = ADDR_W'(OFS_FL_CLR);
  localparam logic [ADDR_W-1:0] A_MK_RD  = ADDR_W'(OFS_MK_RD);
  localparam logic [ADDR_W-1:0] A_MK_SET = ADDR_W'(OFS_MK_SET);
  localparam logic [ADDR_W-1:0] A_MK_CLR = ADDR_W'(OFS_MK_CLR);

  // Write strobes: only alias offsets produce a strobe
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (addr)
        A_EN_SET: strb.enSet   = 1'b1;
        A_EN_CLR: strb.enClr   = 1'b1;
        A_ST_SET: strb.stopSet = 1'b1;
        A_ST_CLR: strb.stopClr = 1'b1;
        A_FL_SET: strb.flagSet = 1'b1;
        A_FL_CLR: strb.flagClr = 1'b1;
        A_MK_SET: strb.maskSet = 1'b1;
        A_MK_CLR: strb.maskClr = 1'b1;
        default:  strb = '0;
      endcase
    end
  end

  // Read select: only base offsets return a vector
  always_comb begin
    case (addr)
      A_EN_RD: rdSel = SEL_EN;
      A_ST_RD: rdSel = SEL_STOP;
      A_FL_RD: rdSel = SEL_FLAG;
      A_MK_RD: rdSel = SEL_MASK;
      default: rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/tmr_ctl_bitreg.sv
module tmr_ctl_bitreg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setStb,
  input  logic         clrStb,
  input  logic [W-1:0] wrBits,
  input  logic [W-1:0] hwSet,
  output logic [W-1:0] q
);

  logic [W-1:0] setMask;
  logic [W-1:0] clrMask;
  logic [W-1:0] qNext;

  assign setMask = setStb ? wrBits : '0;
  assign clrMask = clrStb ? wrBits : '0;
  // Hardware set is applied after the clear so it wins on a collision
  assign qNext   = (q & ~clrMask) | setMask | hwSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= RST_VAL;
    else       q <= qNext;
  end

endmodule

// File: rtl/tmr_ctl_datapath.sv
module tmr_ctl_datapath
  import tmr_ctl_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  rdSel_e            rdSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [NUM_CH-1:0] fullEvt,
  input  logic [NUM_CH-1:0] halfEvt,
  output logic [NUM_CH-1:0] enVec,
  output logic [NUM_CH-1:0] stopVec,
  output logic [WORD_W-1:0] flagVec,
  output logic [WORD_W-1:0] maskVec,
  output logic [WORD_W-1:0] rdData,
  output logic              irq
);

  localparam logic [WORD_W-1:0] IRQ_VALID = irqBits(NUM_CH);

  logic [NUM_CH-1:0] chanBits;
  logic [WORD_W-1:0] irqWrBits;
  logic [WORD_W-1:0] hwFlagSet;

  assign chanBits  = wrData[NUM_CH-1:0];
  assign irqWrBits = wrData & IRQ_VALID;

  // Event pulses placed at their positions in the pending word
  always_comb begin
    hwFlagSet                        = '0;
    hwFlagSet[NUM_CH-1:0]            = fullEvt;
    hwFlagSet[HALF_BASE +: NUM_CH]   = halfEvt;
  end

  tmr_ctl_bitreg #(.W(NUM_CH), .RST_VAL('0)) u_enReg (
    .clk(clk), .rstN(rstN), .setStb(strb.enSet), .clrStb(strb.enClr),
    .wrBits(chanBits), .hwSet('0), .q(enVec)
  );

  tmr_ctl_bitreg #(.W(NUM_CH), .RST_VAL({NUM_CH{1'b1}})) u_stopReg (
    .clk(clk), .rstN(rstN), .setStb(strb.stopSet), .clrStb(strb.stopClr),
    .wrBits(chanBits), .hwSet('0), .q(stopVec)
  );

  tmr_ctl_bitreg #(.W(WORD_W), .RST_VAL('0)) u_flagReg (
    .clk(clk), .rstN(rstN), .setStb(strb.flagSet), .clrStb(strb.flagClr),
    .wrBits(irqWrBits), .hwSet(hwFlagSet), .q(flagVec)
  );

  tmr_ctl_bitreg #(.W(WORD_W), .RST_VAL(IRQ_VALID)) u_maskReg (
    .clk(clk), .rstN(rstN), .setStb(strb.maskSet), .clrStb(strb.maskClr),
    .wrBits(irqWrBits), .hwSet('0), .q(maskVec)
  );

  always_comb begin
    case (rdSel)
      SEL_EN:   rdData = WORD_W'(enVec);
      SEL_STOP: rdData = WORD_W'(stopVec);
      SEL_FLAG: rdData = flagVec;
      SEL_MASK: rdData = maskVec;
      default:  rdData = '0;
    endcase
  end

  assign irq = |(flagVec & ~maskVec);

endmodule

// File: rtl/tmr_ctl_bank.sv
module tmr_ctl_bank
  import tmr_ctl_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [NUM_CH-1:0] fullEvt,
  input  logic [NUM_CH-1:0] halfEvt,
  output logic [NUM_CH-1:0] chanEnable,
  output logic [NUM_CH-1:0] chanStop,
  output logic              irq
);

  wrStrobe_t         strb;
  rdSel_e            rdSel;
  logic [WORD_W-1:0] flagVec;
  logic [WORD_W-1:0] maskVec;

  tmr_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wrEn(wrEn), .addr(addr), .strb(strb), .rdSel(rdSel)
  );

  tmr_ctl_datapath #(.NUM_CH(NUM_CH)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wrData(wrData),
    .fullEvt(fullEvt), .halfEvt(halfEvt), .enVec(chanEnable),
    .stopVec(chanStop), .flagVec(flagVec), .maskVec(maskVec),
    .rdData(rdData), .irq(irq)
  );

endmodule

// File: rtl/tmr_ctl_bank_chk.sv
module tmr_ctl_bank_chk
  import tmr_ctl_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [NUM_CH-1:0] fullEvt,
  input logic [NUM_CH-1:0] halfEvt,
  input logic [NUM_CH-1:0] chanEnable,
  input logic [NUM_CH-1:0] chanStop,
  input logic              irq,
  input logic [31:0]       flagVec,
  input logic [31:0]       maskVec
);

  localparam logic [31:0] VALID = irqBits(NUM_CH);

  // R1: reset leaves halt lines high and mask set
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&chanStop) && (chanEnable == '0) && (maskVec == VALID) && !irq);

  // R2: set alias raises every written enable bit
  p_en_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_EN_SET)) |=>
      ((chanEnable & $past(wrData[NUM_CH-1:0])) == $past(wrData[NUM_CH-1:0])));

  // R2: clear alias drops every written enable bit
  p_en_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_EN_CLR)) |=>
      ((chanEnable & $past(wrData[NUM_CH-1:0])) == '0));

  // R3: clear alias drops halt bits
  p_stop_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_ST_CLR)) |=>
      ((chanStop & $past(wrData[NUM_CH-1:0])) == '0));

  // R5: mask set alias raises every written implemented bit
  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_MK_SET)) |=>
      ((maskVec & $past(wrData & VALID)) == $past(wrData & VALID)));

  // R6: full-match pulse lands in the low half
  p_full_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fullEvt != '0) |=>
      ((flagVec[NUM_CH-1:0] & $past(fullEvt)) == $past(fullEvt)));

  // R6: half-match pulse lands sixteen positions up
  p_half_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (halfEvt != '0) |=>
      ((flagVec[HALF_BASE +: NUM_CH] & $past(halfEvt)) == $past(halfEvt)));

  // R7: event beats a same-cycle clear
  p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_FL_CLR) && fullEvt != '0) |=>
      ((flagVec[NUM_CH-1:0] & $past(fullEvt)) == $past(fullEvt)));

  // R8: irq only rises with a change of pending or mask state
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (!$stable(flagVec) || !$stable(maskVec)));

  // R9: writes to read offsets leave vectors alone
  p_base_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_EN_RD)) |=> $stable(chanEnable));

  p_base_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_ST_RD)) |=> $stable(chanStop));

  // R9: unimplemented positions never set
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec | maskVec) & ~VALID) == '0);

endmodule

bind tmr_ctl_bank tmr_ctl_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .fullEvt(fullEvt), .halfEvt(halfEvt), .chanEnable(chanEnable),
  .chanStop(chanStop), .irq(irq), .flagVec(flagVec), .maskVec(maskVec)
);

// File: tb/tmr_ctl_bank_test.sv
module tmr_ctl_bank_test;

  localparam int NUM_CH = 8;
  localparam int ADDR_W = 6;
  localparam logic [31:0] VALID = 32'h00FF_00FF;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [NUM_CH-1:0] fullEvt = '0;
  logic [NUM_CH-1:0] halfEvt = '0;
  logic [NUM_CH-1:0] chanEnable;
  logic [NUM_CH-1:0] chanStop;
  logic              irq;

  always #2 clk = ~clk;

  tmr_ctl_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .fullEvt(fullEvt), .halfEvt(halfEvt),
    .chanEnable(chanEnable), .chanStop(chanStop), .irq(irq)
  );

  typedef struct {
    logic [31:0]       expData;
    logic [NUM_CH-1:0] expEn;
    logic [NUM_CH-1:0] expStop;
    logic              expIrq;
    string             req;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    errors = 0;
  logic  probe = 1'b0;
  logic  done = 1'b0;

  // Reference model of the register state
  logic [NUM_CH-1:0] mEn   = '0;
  logic [NUM_CH-1:0] mStop = '1;
  logic [31:0]       mFlag = '0;
  logic [31:0]       mMask = VALID;

  function automatic logic [31:0] modelRead(input logic [ADDR_W-1:0] a);
    case (a)
      6'h00:   return {24'd0, mEn};
      6'h0C:   return {24'd0, mStop};
      6'h10:   return mFlag;
      6'h20:   return mMask;
      default: return 32'd0;
    endcase
  endfunction

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
    case (a)
      6'h04: mEn   = mEn | d[NUM_CH-1:0];
      6'h08: mEn   = mEn & ~d[NUM_CH-1:0];
      6'h1C: mStop = mStop | d[NUM_CH-1:0];
      6'h2C: mStop = mStop & ~d[NUM_CH-1:0];
      6'h14: mFlag = mFlag | (d & VALID);
      6'h18: mFlag = mFlag & ~(d & VALID);
      6'h24: mMask = mMask | (d & VALID);
      6'h28: mMask = mMask & ~(d & VALID);
      default: ;
    endcase
  endtask

  task automatic evtPulse(input logic [NUM_CH-1:0] f, input logic [NUM_CH-1:0] h,
                          input logic doClr, input logic [31:0] clrBits);
    @(negedge clk);
    fullEvt = f; halfEvt = h;
    if (doClr) begin wrEn = 1'b1; addr = 6'h18; wrData = clrBits; end
    @(negedge clk);
    fullEvt = '0; halfEvt = '0; wrEn = 1'b0; addr = '0; wrData = '0;
    if (doClr) mFlag = mFlag & ~(clrBits & VALID);
    mFlag = mFlag | {8'd0, h, 8'd0, f};
  endtask

  // Driver side of the scoreboard: present an address and queue the expectation
  task automatic expectRead(input logic [ADDR_W-1:0] a, input string req);
    item_t it;
    @(negedge clk);
    addr = a;
    it.expData = modelRead(a);
    it.expEn   = mEn;
    it.expStop = mStop;
    it.expIrq  = |(mFlag & ~mMask);
    it.req     = req;
    expQ.push_back(it);
    probe = 1'b1;
    @(negedge clk);
    probe = 1'b0;
    addr  = '0;
  endtask

  // Monitor: compare outputs in the low clock phase
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (probe) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: actual no item, expected one queued");
        end else begin
          it = expQ.pop_front();
          if (rdData !== it.expData || chanEnable !== it.expEn ||
              chanStop !== it.expStop || irq !== it.expIrq) begin
            errors++;
            $display("FAIL %s: actual rd=%h en=%h stop=%h irq=%b expected rd=%h en=%h stop=%h irq=%b",
                     it.req, rdData, chanEnable, chanStop, irq,
                     it.expData, it.expEn, it.expStop, it.expIrq);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    expectRead(6'h00, "R1 enable");
    expectRead(6'h0C, "R1 stop");
    expectRead(6'h10, "R1 flag");
    expectRead(6'h20, "R1 mask");

    // R2 enable set/clear with untouched neighbours
    busWrite(6'h04, 32'h05);
    expectRead(6'h00, "R2 set 05");
    busWrite(6'h04, 32'h80);
    expectRead(6'h00, "R2 set keeps others");
    busWrite(6'h08, 32'h04);
    expectRead(6'h00, "R2 clear one bit");

    // R3 halt set/clear
    busWrite(6'h2C, 32'h0F);
    expectRead(6'h0C, "R3 clear low nibble");
    busWrite(6'h1C, 32'h01);
    expectRead(6'h0C, "R3 set bit0");

    // R4 software pending set while masked: irq stays low
    busWrite(6'h14, 32'h0003_0001);
    expectRead(6'h10, "R4 sw set masked");
    // R5 unmask bit0 -> R8 irq raised
    busWrite(6'h28, 32'h0000_0001);
    expectRead(6'h20, "R5 mask clear");
    expectRead(6'h10, "R8 irq unmasked");
    busWrite(6'h18, 32'h0003_0001);
    expectRead(6'h10, "R4 sw clear");
    busWrite(6'h24, 32'h0000_0001);
    expectRead(6'h20, "R5 mask set");

    // R6 hardware events
    evtPulse(8'h40, 8'h00, 1'b0, 32'd0);
    expectRead(6'h10, "R6 full bit6");
    evtPulse(8'h00, 8'h02, 1'b0, 32'd0);
    expectRead(6'h10, "R6 half bit17");

    // R7 event and clear of the same bit in one cycle
    evtPulse(8'h08, 8'h00, 1'b1, 32'h0002_0048);
    expectRead(6'h10, "R7 hw set wins");

    // R8 clear pending, then unmask: no stale interrupt
    busWrite(6'h18, 32'h0000_0008);
    busWrite(6'h28, 32'h0000_0008);
    expectRead(6'h10, "R8 stale not fired");
    evtPulse(8'h08, 8'h00, 1'b0, 32'd0);
    expectRead(6'h10, "R8 new event fires");

    // R9 base offsets ignore writes; unused bits stay 0
    busWrite(6'h00, 32'hFFFF_FFFF);
    busWrite(6'h0C, 32'h0000_0000);
    busWrite(6'h10, 32'hFFFF_FFFF);
    busWrite(6'h20, 32'h0000_0000);
    expectRead(6'h00, "R9 enable base");
    expectRead(6'h0C, "R9 stop base");
    expectRead(6'h20, "R9 mask base");
    busWrite(6'h14, 32'hFFFF_FFFF);
    expectRead(6'h10, "R9 flag unused bits");
    busWrite(6'h24, 32'hFFFF_FFFF);
    expectRead(6'h20, "R9 mask unused bits");

    // R10 unmapped and misaligned offsets read zero
    expectRead(6'h30, "R10 unmapped");
    expectRead(6'h01, "R10 misaligned");
    expectRead(6'h04, "R10 alias reads zero");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule